// File: doc/BRIEF.md
# Offset-Based Tick Counter Register

This block provides a 64-bit time-stamp register for a processor core. A free-running event counter advances on each retired instruction, and a stored offset turns that raw count into the visible value. Software never writes the counter itself. A write stores a fresh offset, so the visible value starts again from the written number and keeps advancing from there.

Three register selectors share this one counter and offset: tick, system tick and privileged tick. A write through any of them is seen by reads through all of them. The top bit of the visible value is a stored flag, not a counted bit. While the flag is set, a non-privileged read of the tick or system-tick selector raises a privilege trap instead of returning data. A write through the system-tick selector needs hypervisor privilege. Without it the write raises an illegal-instruction trap and changes nothing.

Top module: `tick_offset_reg`

## Requirements
- R1: After reset the counter is zero, the stored flag is 1 and the stored offset is zero, so a permitted read returns 0x8000_0000_0000_0000.
- R2: A permitted read returns bits 62:2 of (count minus offset, modulo 2^64), with bits 1:0 forced to zero and bit 63 equal to the stored flag.
- R3: The write value V is opa_i XOR opb_i. A permitted write stores (count minus V) with bit 63 cleared as the offset, and stores V[63] as the flag. With no retire in between, the next read returns V with bits 1:0 cleared.
- R4: acc_sel_i codes are 0 tick, 1 system tick, 2 privileged tick and 3 unmapped. Codes 0 to 2 share one counter and offset. With code 3, a write is ignored and a read returns zero without a trap.
- R5: The count advances by one on each cycle with retire_i=1 and uop_last_i=1. A retire with uop_last_i=0 leaves the count unchanged.
- R6: The count and both subtractions wrap modulo 2^64. A write of V larger than the count still reads back as V.
- R7: A read with priv_i=0, selector 0 or 1 and the flag set gives rd_trap_o=1 and rd_data_o=0 in the same cycle. A privileged read, or a read with selector 2, returns data.
- R8: A write with selector 1 and hpriv_i=0 gives wr_trap_o=1 in the same cycle and leaves the offset and the flag unchanged.
- R9: A read in the same cycle as a write returns the value from before the write. The written value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An operation retires this cycle |
| uop_last_i | input | 1 | The retiring operation is the last of its micro-op sequence, or is not split |
| acc_rd_i | input | 1 | Read request |
| acc_wr_i | input | 1 | Write request |
| acc_sel_i | input | 2 | Register selector (0 tick, 1 system tick, 2 privileged tick, 3 unmapped) |
| priv_i | input | 1 | Privileged mode is active |
| hpriv_i | input | 1 | Hypervisor mode is active |
| opa_i | input | 64 | First write operand |
| opb_i | input | 64 | Second write operand |
| rd_data_o | output | 64 | Read data, zero when no permitted read is made |
| rd_trap_o | output | 1 | Privilege trap for the current read |
| wr_trap_o | output | 1 | Illegal-instruction trap for the current write |

## Verification
The counter is driven with bursts of retires whose last-micro-op flag is set and with bursts where it is clear. This separates real instruction counting from counting every micro-op, and the masked low bits show up when the count is not a multiple of four. Writes are made through each selector and read back through a different one, which shows whether the three selectors share one state or hold separate copies. A written value above the current count checks that the subtraction wraps. A read and a write in the same cycle separate old data from new. Reads are then repeated with each combination of privilege, flag state and selector, which tells a trap apart from a data return and an illegal write apart from a permitted one.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic [1:0] {
      SEL_TICK  = 2'd0,
      SEL_STICK = 2'd1,
      SEL_PTICK = 2'd2,
      SEL_NONE  = 2'd3
   } tick_sel_e;
endpackage

// File: rtl/tick_event_counter.sv
module tick_event_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   input  logic             last_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic step;
   assign step = retire_i & last_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_o <= '0;
      else if (step) cnt_o <= cnt_o + {{(CNT_W-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/tick_access_ctl.sv
module tick_access_ctl
   import tick_pkg::*;
(
   input  logic       rd_i,
   input  logic       wr_i,
   input  logic [1:0] sel_i,
   input  logic       priv_i,
   input  logic       hpriv_i,
   input  logic       flag_i,
   output logic       rd_ok_o,
   output logic       rd_trap_o,
   output logic       wr_ok_o,
   output logic       wr_trap_o
);
   tick_sel_e sel;
   logic      mapped;
   logic      guarded;

   always_comb begin
      sel     = tick_sel_e'(sel_i);
      mapped  = (sel != SEL_NONE);
      guarded = (sel == SEL_TICK) || (sel == SEL_STICK);
      rd_trap_o = rd_i && guarded && flag_i && !priv_i;
      rd_ok_o   = rd_i && mapped && !rd_trap_o;
      wr_trap_o = wr_i && (sel == SEL_STICK) && !hpriv_i;
      wr_ok_o   = wr_i && mapped && !wr_trap_o;
   end
endmodule

// File: rtl/tick_offset_store.sv
module tick_offset_store #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-2:0] off_o,
   output logic             flag_o
);
   logic [CNT_W-1:0] new_off;
   assign new_off = cnt_i - wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_o  <= '0;
         flag_o <= 1'b1;
      end else if (wr_ok_i) begin
         off_o  <= new_off[CNT_W-2:0];
         flag_o <= wdata_i[CNT_W-1];
      end
   end
endmodule

// File: rtl/tick_read_view.sv
module tick_read_view #(
   parameter int CNT_W     = 64,
   parameter int ZERO_LSBS = 2
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-2:0] off_i,
   input  logic             flag_i,
   input  logic             rd_ok_i,
   output logic [CNT_W-1:0] data_o
);
   logic [CNT_W-1:0] diff;
   logic [CNT_W-2:0] body;

   assign diff = cnt_i - {1'b0, off_i};

   generate
      if (ZERO_LSBS == 0) begin : g_full
         assign body = diff[CNT_W-2:0];
      end else begin : g_masked
         assign body = {diff[CNT_W-2:ZERO_LSBS], {ZERO_LSBS{1'b0}}};
      end
   endgenerate

   assign data_o = rd_ok_i ? {flag_i, body} : '0;
endmodule

// File: rtl/tick_offset_reg.sv
module tick_offset_reg #(
   parameter int CNT_W     = 64,
   parameter int ZERO_LSBS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   input  logic             uop_last_i,
   input  logic             acc_rd_i,
   input  logic             acc_wr_i,
   input  logic [1:0]       acc_sel_i,
   input  logic             priv_i,
   input  logic             hpriv_i,
   input  logic [CNT_W-1:0] opa_i,
   input  logic [CNT_W-1:0] opb_i,
   output logic [CNT_W-1:0] rd_data_o,
   output logic             rd_trap_o,
   output logic             wr_trap_o
);
   localparam int OFF_W = CNT_W - 1;

   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("tick_offset_reg: CNT_W must be at least 8");
      end
      if (ZERO_LSBS < 0 || ZERO_LSBS > CNT_W - 2) begin : g_bad_mask
         $error("tick_offset_reg: ZERO_LSBS out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [OFF_W-1:0] off_q;
   logic             flag_q;
   logic             rd_ok, wr_ok;
   logic [CNT_W-1:0] wdata;

   assign wdata = opa_i ^ opb_i;

   tick_event_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .retire_i (retire_i),
      .last_i   (uop_last_i),
      .cnt_o    (cnt_q)
   );

   tick_access_ctl u_ctl (
      .rd_i      (acc_rd_i),
      .wr_i      (acc_wr_i),
      .sel_i     (acc_sel_i),
      .priv_i    (priv_i),
      .hpriv_i   (hpriv_i),
      .flag_i    (flag_q),
      .rd_ok_o   (rd_ok),
      .rd_trap_o (rd_trap_o),
      .wr_ok_o   (wr_ok),
      .wr_trap_o (wr_trap_o)
   );

   tick_offset_store #(.CNT_W(CNT_W)) u_off (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ok_i (wr_ok),
      .wdata_i (wdata),
      .cnt_i   (cnt_q),
      .off_o   (off_q),
      .flag_o  (flag_q)
   );

   tick_read_view #(.CNT_W(CNT_W), .ZERO_LSBS(ZERO_LSBS)) u_view (
      .cnt_i   (cnt_q),
      .off_i   (off_q),
      .flag_i  (flag_q),
      .rd_ok_i (rd_ok),
      .data_o  (rd_data_o)
   );
endmodule

// File: rtl/tick_offset_reg_chk.sv
module tick_offset_reg_chk #(
   parameter int CNT_W     = 64,
   parameter int ZERO_LSBS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             retire_i,
   input logic             uop_last_i,
   input logic             acc_wr_i,
   input logic [1:0]       acc_sel_i,
   input logic [CNT_W-1:0] opa_i,
   input logic [CNT_W-1:0] opb_i,
   input logic [CNT_W-1:0] rd_data_o,
   input logic             rd_trap_o,
   input logic             wr_trap_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-2:0] off_q,
   input logic             flag_q
);
   logic [CNT_W-1:0] exp_off;
   logic             wr_taken;
   assign exp_off  = cnt_q - (opa_i ^ opb_i);
   assign wr_taken = acc_wr_i && (acc_sel_i != 2'd3) && !wr_trap_o;

   // R5
   a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && uop_last_i) |=> cnt_q == $past(cnt_q) + 1'b1);
   // R5
   a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(retire_i && uop_last_i) |=> cnt_q == $past(cnt_q));
   // R3
   a_r3_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wr_taken |=> flag_q == $past(opa_i[CNT_W-1] ^ opb_i[CNT_W-1]));
   // R3
   a_r3_write_off: assert property (@(posedge clk) disable iff (!rst_n)
      wr_taken |=> off_q == $past(exp_off[CNT_W-2:0]));
   // R8
   a_r8_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_trap_o |=> ($stable(off_q) && $stable(flag_q)));
   // R7
   a_r7_trap_blank: assert property (@(posedge clk) disable iff (!rst_n)
      rd_trap_o |-> rd_data_o == '0);
   // R2
   a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[ZERO_LSBS-1:0] == '0);
endmodule

bind tick_offset_reg tick_offset_reg_chk #(.CNT_W(CNT_W), .ZERO_LSBS(ZERO_LSBS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .retire_i   (retire_i),
   .uop_last_i (uop_last_i),
   .acc_wr_i   (acc_wr_i),
   .acc_sel_i  (acc_sel_i),
   .opa_i      (opa_i),
   .opb_i      (opb_i),
   .rd_data_o  (rd_data_o),
   .rd_trap_o  (rd_trap_o),
   .wr_trap_o  (wr_trap_o),
   .cnt_q      (cnt_q),
   .off_q      (off_q),
   .flag_q     (flag_q)
);

// File: tb/tick_offset_reg_tb.sv
module tick_offset_reg_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire_i = 0, uop_last_i = 0, acc_rd_i = 0, acc_wr_i = 0;
   logic [1:0]  acc_sel_i = 0;
   logic        priv_i = 0, hpriv_i = 0;
   logic [63:0] opa_i = 0, opb_i = 0;
   logic [63:0] rd_data_o;
   logic        rd_trap_o, wr_trap_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [63:0] m_cnt;
   logic [62:0] m_off;
   logic        m_flag;
   logic [63:0] obs_data;
   logic        obs_rtrap, obs_wtrap;

   always #(CLK_P/2) clk = ~clk;

   tick_offset_reg u_dut (
      .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .uop_last_i(uop_last_i),
      .acc_rd_i(acc_rd_i), .acc_wr_i(acc_wr_i), .acc_sel_i(acc_sel_i),
      .priv_i(priv_i), .hpriv_i(hpriv_i), .opa_i(opa_i), .opb_i(opb_i),
      .rd_data_o(rd_data_o), .rd_trap_o(rd_trap_o), .wr_trap_o(wr_trap_o)
   );

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   function automatic logic [63:0] exp_read();
      logic [63:0] d;
      d = m_cnt - {1'b0, m_off};
      return {m_flag, d[62:2], 2'b00};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, capture outputs, update model at posedge
   task automatic step(input logic rd, input logic wr, input logic [1:0] sel,
                       input logic pv, input logic hv, input logic [63:0] a,
                       input logic [63:0] b, input logic ret, input logic last);
      logic [63:0] v;
      logic [63:0] no;
      acc_rd_i = rd; acc_wr_i = wr; acc_sel_i = sel; priv_i = pv; hpriv_i = hv;
      opa_i = a; opb_i = b; retire_i = ret; uop_last_i = last;
      #(CLK_P/4);
      obs_data = rd_data_o; obs_rtrap = rd_trap_o; obs_wtrap = wr_trap_o;
      @(posedge clk);
      v = a ^ b;
      if (wr && sel != 2'd3 && !(sel == 2'd1 && !hv)) begin
         no = m_cnt - v;
         m_off = no[62:0];
         m_flag = v[63];
      end
      if (ret && last) m_cnt = m_cnt + 64'd1;
      @(negedge clk);
      acc_rd_i = 0; acc_wr_i = 0; retire_i = 0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] sel, input logic pv);
      logic [63:0] e;
      e = exp_read();
      step(1, 0, sel, pv, 0, 0, 0, 0, 0);
      check(req, obs_data, e);
   endtask

   task automatic t_reset();
      rd_chk("R1 reset value", 2'd0, 1);
      check("R1 reset value literal", obs_data, 64'h8000_0000_0000_0000);
   endtask

   task automatic t_count();
      step(0, 1, 2'd2, 1, 1, 64'h0, 64'h0, 0, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      rd_chk("R5 four retires", 2'd0, 1);
      check("R5 four retires literal", obs_data, 64'd4);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 0);
      rd_chk("R5 non-last uops", 2'd0, 1);
      check("R5 non-last literal", obs_data, 64'd4);
      for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      rd_chk("R2 low bits masked", 2'd0, 1);
      check("R2 six reads four", obs_data, 64'd4);
      for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      rd_chk("R2 eight", 2'd0, 1);
      check("R2 eight literal", obs_data, 64'd8);
   endtask

   task automatic t_write();
      step(0, 1, 2'd0, 1, 0, 64'h0123_4567_0000_0000, 64'h0000_0000_89AB_CDEF, 0, 0);
      rd_chk("R3 write readback", 2'd0, 1);
      check("R3 write literal", obs_data, 64'h0123_4567_89AB_CDEC);
      step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      rd_chk("R3 counts on", 2'd2, 1);
      check("R3 counts on literal", obs_data, 64'h0123_4567_89AB_CDF0);
   endtask

   task automatic t_alias();
      step(0, 1, 2'd1, 1, 1, 64'h1000, 64'h0, 0, 0);
      rd_chk("R4 stick write seen via tick", 2'd0, 1);
      check("R4 alias literal", obs_data, 64'h1000);
      rd_chk("R4 seen via ptick", 2'd2, 1);
      check("R4 ptick literal", obs_data, 64'h1000);
      step(0, 1, 2'd3, 1, 1, 64'h5555, 64'h0, 0, 0);
      check("R4 unmapped write no trap", {63'b0, obs_wtrap}, 64'd0);
      rd_chk("R4 unmapped write ignored", 2'd0, 1);
      check("R4 ignored literal", obs_data, 64'h1000);
      step(1, 0, 2'd3, 1, 1, 0, 0, 0, 0);
      check("R4 unmapped read zero", obs_data, 64'd0);
      check("R4 unmapped read no trap", {63'b0, obs_rtrap}, 64'd0);
   endtask

   task automatic t_wrap();
      step(0, 1, 2'd0, 1, 0, 64'h7FFF_FFFF_FFFF_FFFC, 64'h0, 0, 0);
      rd_chk("R6 large value", 2'd0, 1);
      check("R6 large literal", obs_data, 64'h7FFF_FFFF_FFFF_FFFC);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      rd_chk("R6 wraps to zero", 2'd0, 1);
      check("R6 wrap literal", obs_data, 64'd0);
   endtask

   task automatic t_trap();
      step(0, 1, 2'd2, 1, 1, 64'h8000_0000_0000_0100, 64'h0, 0, 0);
      step(1, 0, 2'd0, 0, 0, 0, 0, 0, 0);
      check("R7 tick nonpriv trap", {63'b0, obs_rtrap}, 64'd1);
      check("R7 trap data zero", obs_data, 64'd0);
      step(1, 0, 2'd1, 0, 0, 0, 0, 0, 0);
      check("R7 stick nonpriv trap", {63'b0, obs_rtrap}, 64'd1);
      rd_chk("R7 ptick nonpriv data", 2'd2, 0);
      check("R7 ptick literal", obs_data, 64'h8000_0000_0000_0100);
      rd_chk("R7 priv read data", 2'd0, 1);
      check("R7 priv no trap", {63'b0, obs_rtrap}, 64'd0);
      step(0, 1, 2'd0, 1, 0, 64'h200, 64'h0, 0, 0);
      rd_chk("R7 flag clear no trap", 2'd0, 0);
      check("R7 flag clear literal", obs_data, 64'h200);
   endtask

   task automatic t_illegal();
      step(0, 1, 2'd1, 1, 0, 64'hFFFF, 64'h0, 0, 0);
      check("R8 illegal trap", {63'b0, obs_wtrap}, 64'd1);
      rd_chk("R8 state unchanged", 2'd0, 1);
      check("R8 unchanged literal", obs_data, 64'h200);
      step(0, 1, 2'd0, 1, 0, 64'hFFFF, 64'h0, 0, 0);
      check("R8 tick write no trap", {63'b0, obs_wtrap}, 64'd0);
   endtask

   task automatic t_same_cycle();
      logic [63:0] e;
      e = exp_read();
      step(1, 1, 2'd0, 1, 0, 64'h4440, 64'h0, 0, 0);
      check("R9 old value on same cycle", obs_data, e);
      rd_chk("R9 new value next cycle", 2'd0, 1);
      check("R9 new literal", obs_data, 64'h4440);
   endtask

   initial begin
      m_cnt = 0; m_off = 0; m_flag = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_write();
      t_alias();
      t_wrap();
      t_trap();
      t_illegal();
      t_same_cycle();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule